// File: doc/BRIEF.md
# Reloadable Event Counter Timer

This block counts edges on an external event input. It divides them through two cascaded down-counting stages, a prescaler and a main counter. Each stage has its own reload register. Every accepted edge decrements the prescaler. When the prescaler is at zero, the next accepted edge reloads it and decrements the main counter instead. When the main counter is also at zero, that edge reloads both stages and raises a one-cycle interrupt. With a prescaler setting n and a main setting m, the timer therefore produces one interrupt every (n+1)(m+1) accepted edges.

Software controls the timer through a small register port with four addresses:

- A control register holds the run flag and a forced-stop command.
- Two data registers write both the reload value and the live count of a stage at once. Reading them returns the live count.
- A mode register selects the active edge, chooses one of two event pins, enables a gating window input, and configures an optional toggling pulse output.

The event pins are asynchronous to the clock, so they are synchronized before edge detection. The gate input is synchronous to the clock.

Top module: `ev_timer`

## Requirements
- R1: After reset, every register reads 0 at all four addresses (0 control, 1 prescaler, 2 main counter, 3 mode), `irqPulse` is 0 and `pulseOut` is 0.
- R2: A write to address 1 or 2 loads the written value into both that stage's reload register and its live counter. This holds whether the timer is stopped or running, and a read of the same address returns the value on the next cycle.
- R3: Edges are counted only while the run flag (control bit 0) is 1. Each counted edge decrements the prescaler. When the prescaler is 0, a counted edge reloads it and decrements the main counter instead. While stopped, both counts hold.
- R4: A counted edge that finds both stages at 0 reloads both stages and produces a one-cycle `irqPulse`. After a load, interrupts arrive every (n+1)(m+1) counted edges.
- R5: Mode bit 1 selects the active edge: 0 counts rising edges only, 1 counts falling edges only.
- R6: Mode bit 2 selects the event source: 0 uses `evtPinA`, 1 uses `evtPinB`. Edges on the unselected pin have no effect.
- R7: When mode bit 3 is 1, edges that arrive while `gateOpen` is 0 are ignored. When mode bit 3 is 0, `gateOpen` has no effect.
- R8: Writing control bit 0 as 0 stops counting. Writing control bit 1 as 1 stops counting and clears the run flag, whatever the value of bit 0. Control bit 1 always reads 0.
- R9: Writing the mode register sets the output level to mode bit 4. Each underflow then inverts that level. `pulseOut` shows the level while mode bit 0 is 1 and is held at 0 while mode bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 prescaler, 2 main, 3 mode) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for `regAddr` (combinational) |
| evtPinA | input | 1 | Event input, source 0 |
| evtPinB | input | 1 | Event input, source 1 |
| gateOpen | input | 1 | Event gating window, synchronous to `clk` |
| irqPulse | output | 1 | One-cycle pulse on main-counter underflow |
| pulseOut | output | 1 | Toggling underflow output |

## Verification
A wrong prescaler or main count shows up at the register port within a cycle. It also shifts the moment of the next interrupt by whole edge periods, so the bench reads both stages back between edges and counts interrupts after each burst. A stuck or mis-set output level shows at `pulseOut` on the first underflow after a mode write. A wrongly held run flag or wrong edge or pin selection shows as an interrupt that appears or goes missing within about four clock cycles of the offending pin transition.

// File: rtl/ev_timer_pkg.sv
package ev_timer_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_PRE  = 2'd1,
    ADDR_MAIN = 2'd2,
    ADDR_MODE = 2'd3
  } regAddr_e;

  // Mode register bit positions
  localparam int MODE_OUT_EN = 0;
  localparam int MODE_FALL   = 1;
  localparam int MODE_PIN_B  = 2;
  localparam int MODE_GATE   = 3;
  localparam int MODE_INIT   = 4;
  localparam int MODE_W      = 5;

  // Control register bit positions
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_STOP = 1;

  typedef struct packed {
    logic loadPre;
    logic loadMain;
    logic countEvt;
    logic setLevel;
    logic initLevel;
  } dpStrobes_t;

endpackage

// File: rtl/ev_timer_ctrl.sv
module ev_timer_ctrl
  import ev_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  input  logic             evtPinA,
  input  logic             evtPinB,
  input  logic             gateOpen,
  input  logic [CNT_W-1:0] preCnt,
  input  logic [CNT_W-1:0] mainCnt,
  output dpStrobes_t       strobes,
  output logic             outEnable,
  output logic [CNT_W-1:0] regRdata
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0]  syncA, syncB;
  logic               prevLvl, selLvl, edgeHit, gateOk;
  logic               runFlag;
  logic [MODE_W-1:0]  modeReg;
  logic               wrCtrl, wrMode;

  assign wrCtrl = regWe && (regAddr == ADDR_CTRL);
  assign wrMode = regWe && (regAddr == ADDR_MODE);

  // Synchronizers for both event pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= {syncA[SYNC_MSB-1:0], evtPinA};
      syncB <= {syncB[SYNC_MSB-1:0], evtPinB};
    end
  end

  assign selLvl = modeReg[MODE_PIN_B] ? syncB[SYNC_MSB] : syncA[SYNC_MSB];

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= selLvl;
  end

  assign edgeHit = modeReg[MODE_FALL] ? (prevLvl & ~selLvl) : (~prevLvl & selLvl);
  assign gateOk  = !modeReg[MODE_GATE] || gateOpen;

  // Run flag and mode register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runFlag <= 1'b0;
      modeReg <= '0;
    end else begin
      if (wrCtrl) runFlag <= regWdata[CTRL_STOP] ? 1'b0 : regWdata[CTRL_RUN];
      if (wrMode) modeReg <= regWdata[MODE_W-1:0];
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.loadPre   = regWe && (regAddr == ADDR_PRE);
    strobes.loadMain  = regWe && (regAddr == ADDR_MAIN);
    strobes.countEvt  = edgeHit && runFlag && gateOk;
    strobes.setLevel  = wrMode;
    strobes.initLevel = regWdata[MODE_INIT];
  end

  assign outEnable = modeReg[MODE_OUT_EN];

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdata = {{(CNT_W-1){1'b0}}, runFlag};
      ADDR_PRE:  regRdata = preCnt;
      ADDR_MAIN: regRdata = mainCnt;
      default:   regRdata = {{(CNT_W-MODE_W){1'b0}}, modeReg};
    endcase
  end

  // R8: forced stop always leaves the run flag cleared
  assert_force_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && regWdata[CTRL_STOP]) |=> !runFlag);

  // R3: a stopped timer leaves the prescaler unchanged unless software writes it
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runFlag && !(regWe && regAddr == ADDR_PRE)) |=> $stable(preCnt));

endmodule

// File: rtl/ev_timer_dp.sv
module ev_timer_dp
  import ev_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [CNT_W-1:0] wdata,
  input  logic             outEnable,
  output logic [CNT_W-1:0] preCnt,
  output logic [CNT_W-1:0] mainCnt,
  output logic             irqPulse,
  output logic             pulseOut
);

  logic [CNT_W-1:0] preReload, mainReload;
  logic             outLvl;
  logic             stepOk, preZero, mainZero, underflow;

  // A register write in the same cycle wins over a count step
  assign stepOk    = strobes.countEvt && !strobes.loadPre && !strobes.loadMain;
  assign preZero   = (preCnt == '0);
  assign mainZero  = (mainCnt == '0);
  assign underflow = stepOk && preZero && mainZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt     <= '0;
      mainCnt    <= '0;
      preReload  <= '0;
      mainReload <= '0;
      irqPulse   <= 1'b0;
    end else begin
      irqPulse <= underflow;
      if (strobes.loadPre) begin
        preReload <= wdata;
        preCnt    <= wdata;
      end
      if (strobes.loadMain) begin
        mainReload <= wdata;
        mainCnt    <= wdata;
      end
      if (stepOk) begin
        if (preZero) begin
          preCnt <= preReload;
          if (mainZero) mainCnt <= mainReload;
          else          mainCnt <= mainCnt - 1'b1;
        end else begin
          preCnt <= preCnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 outLvl <= 1'b0;
    else if (strobes.setLevel) outLvl <= strobes.initLevel;
    else if (underflow)        outLvl <= ~outLvl;
  end

  assign pulseOut = outEnable & outLvl;

  // R4: an interrupt coincides with both stages holding their reload values
  assert_irq_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (mainCnt == mainReload && preCnt == preReload));

  // R4: interrupt is a single-cycle pulse
  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R2: a main-counter write lands in the live count
  assert_load_main_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadMain |=> (mainCnt == $past(wdata)));

  // R9: each underflow inverts the output level unless a mode write preset it
  assert_toggle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && !$past(strobes.setLevel)) |-> (outLvl != $past(outLvl)));

endmodule

// File: rtl/ev_timer.sv
module ev_timer
  import ev_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output logic [CNT_W-1:0] regRdata,
  input  logic             evtPinA,
  input  logic             evtPinB,
  input  logic             gateOpen,
  output logic             irqPulse,
  output logic             pulseOut
);

  dpStrobes_t       strobes;
  logic             outEnable;
  logic [CNT_W-1:0] preCnt, mainCnt;

  ev_timer_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .evtPinA(evtPinA), .evtPinB(evtPinB), .gateOpen(gateOpen),
    .preCnt(preCnt), .mainCnt(mainCnt),
    .strobes(strobes), .outEnable(outEnable), .regRdata(regRdata)
  );

  ev_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .wdata(regWdata), .outEnable(outEnable),
    .preCnt(preCnt), .mainCnt(mainCnt),
    .irqPulse(irqPulse), .pulseOut(pulseOut)
  );

endmodule

// File: tb/ev_timer_tb_top.sv
`timescale 1ns/1ps
module ev_timer_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       evtPinA = 1'b0, evtPinB = 1'b0, gateOpen = 1'b0;
  logic       irqPulse, pulseOut;

  int checks = 0;
  int errors = 0;
  int irqCount = 0;

  always #10 clk = ~clk;

  ev_timer dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .evtPinA(evtPinA), .evtPinB(evtPinB), .gateOpen(gateOpen),
    .irqPulse(irqPulse), .pulseOut(pulseOut)
  );

  always @(negedge clk) if (rstN && irqPulse) irqCount++;

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic pulsePin(input bit useB, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (useB) evtPinB = 1'b1; else evtPinA = 1'b1;
      repeat (3) @(negedge clk);
      if (useB) evtPinB = 1'b0; else evtPinA = 1'b0;
      repeat (3) @(negedge clk);
    end
    settle();
  endtask

  task automatic testReset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      readReg(a[1:0], d);
      checkEq($sformatf("R1 reset read addr %0d", a), d, 0);
    end
    checkEq("R1 reset irqPulse", irqPulse, 0);
    checkEq("R1 reset pulseOut", pulseOut, 0);
  endtask

  task automatic testLoadStopped();
    logic [7:0] d;
    writeReg(2'd1, 8'd3);
    writeReg(2'd2, 8'd2);
    readReg(2'd1, d); checkEq("R2 prescaler load", d, 3);
    readReg(2'd2, d); checkEq("R2 main load", d, 2);
    pulsePin(0, 5);
    readReg(2'd1, d); checkEq("R3 stopped prescaler holds", d, 3);
    readReg(2'd2, d); checkEq("R3 stopped main holds", d, 2);
  endtask

  task automatic testDivide();
    logic [7:0] d;
    int base;
    writeReg(2'd1, 8'd1);
    writeReg(2'd2, 8'd2);
    writeReg(2'd0, 8'h01);
    base = irqCount;
    pulsePin(0, 5);
    readReg(2'd1, d); checkEq("R3 prescaler after 5 edges", d, 0);
    readReg(2'd2, d); checkEq("R3 main after 5 edges", d, 0);
    checkEq("R4 no irq before 6th edge", irqCount - base, 0);
    pulsePin(0, 1);
    checkEq("R4 irq on 6th edge", irqCount - base, 1);
    readReg(2'd1, d); checkEq("R4 prescaler reloaded", d, 1);
    readReg(2'd2, d); checkEq("R4 main reloaded", d, 2);
    pulsePin(0, 6);
    checkEq("R4 second period", irqCount - base, 2);
    writeReg(2'd2, 8'd7);
    readReg(2'd2, d); checkEq("R2 write while running", d, 7);
  endtask

  task automatic testFalling();
    int base;
    writeReg(2'd1, 8'd0);
    writeReg(2'd2, 8'd0);
    writeReg(2'd3, 8'h02);
    base = irqCount;
    @(negedge clk) evtPinA = 1'b1;
    repeat (6) @(negedge clk);
    checkEq("R5 rising ignored in falling mode", irqCount - base, 0);
    evtPinA = 1'b0;
    repeat (6) @(negedge clk);
    checkEq("R5 falling edge counted", irqCount - base, 1);
    writeReg(2'd3, 8'h00);
    base = irqCount;
    @(negedge clk) evtPinA = 1'b1;
    repeat (6) @(negedge clk);
    checkEq("R5 rising counted in rising mode", irqCount - base, 1);
    evtPinA = 1'b0;
    repeat (6) @(negedge clk);
    checkEq("R5 falling ignored in rising mode", irqCount - base, 1);
  endtask

  task automatic testPinSelect();
    int base;
    writeReg(2'd3, 8'h04);
    base = irqCount;
    pulsePin(0, 3);
    checkEq("R6 unselected pin A ignored", irqCount - base, 0);
    pulsePin(1, 2);
    checkEq("R6 pin B counted", irqCount - base, 2);
    writeReg(2'd3, 8'h00);
    base = irqCount;
    pulsePin(1, 2);
    checkEq("R6 unselected pin B ignored", irqCount - base, 0);
  endtask

  task automatic testGate();
    int base;
    writeReg(2'd3, 8'h08);
    gateOpen = 1'b0;
    base = irqCount;
    pulsePin(0, 3);
    checkEq("R7 closed gate blocks", irqCount - base, 0);
    gateOpen = 1'b1;
    pulsePin(0, 2);
    checkEq("R7 open gate passes", irqCount - base, 2);
    writeReg(2'd3, 8'h00);
    gateOpen = 1'b0;
    base = irqCount;
    pulsePin(0, 1);
    checkEq("R7 gate unused when disabled", irqCount - base, 1);
  endtask

  task automatic testStop();
    logic [7:0] d;
    int base;
    writeReg(2'd0, 8'h00);
    base = irqCount;
    pulsePin(0, 2);
    checkEq("R8 stop by run=0", irqCount - base, 0);
    writeReg(2'd0, 8'h01);
    pulsePin(0, 1);
    checkEq("R8 restart counts", irqCount - base, 1);
    writeReg(2'd0, 8'h03);
    readReg(2'd0, d);
    checkEq("R8 forced stop clears run", d, 0);
    pulsePin(0, 2);
    checkEq("R8 forced stop blocks edges", irqCount - base, 1);
    writeReg(2'd0, 8'h01);
  endtask

  task automatic testPulseOut();
    writeReg(2'd3, 8'h11);
    checkEq("R9 initial level high", pulseOut, 1);
    pulsePin(0, 1);
    checkEq("R9 toggle to low", pulseOut, 0);
    pulsePin(0, 1);
    checkEq("R9 toggle to high", pulseOut, 1);
    writeReg(2'd3, 8'h01);
    checkEq("R9 initial level low", pulseOut, 0);
    pulsePin(0, 1);
    checkEq("R9 toggle from low", pulseOut, 1);
    writeReg(2'd3, 8'h10);
    checkEq("R9 disabled output low", pulseOut, 0);
    pulsePin(0, 1);
    checkEq("R9 disabled output stays low", pulseOut, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoadStopped();
    testDivide();
    testFalling();
    testPinSelect();
    testGate();
    testStop();
    testPulseOut();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule